// File: doc/BRIEF.md
# Change-Order Sequence Detector

This block watches two single-bit control lines and raises its result bit according to the order in which those lines change, not only their present levels. The result goes high when either line rises while the other is already high. It goes low when the first line falls while the second is still high. Every other legal change leaves the result where it was. Both lines are sampled on the system clock. Each sample is compared with the one before it, so the block sees which line moved and in which direction.

The block assumes that only one line changes between two samples. The behaviour is held in a four-state machine built from a merged flow table. The states are coded so that every transition the machine can take flips exactly one state bit. The state code is brought out for observation. A sample in which both lines moved at once is reported on a one-cycle flag, and that sample leaves the state untouched.

Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `order_det`

## Requirements
- R1: While reset is asserted, and after it is released with both lines low, `seen` is 0, `phase` is 2'b00 and `clash` is 0.
- R2: When `sig_x` rises while `sig_y` is 1 (the sample moves from {x,y}=01 to 11), `seen` is 1 and `phase` is 2'b01 one clock edge later.
- R3: When `sig_y` rises while `sig_x` is 1 (10 to 11), `seen` is 1 and `phase` is 2'b01 one clock edge later.
- R4: When `sig_x` falls while `sig_y` is 1 (11 to 01) and `phase` is 2'b01, `seen` drops to 0 and `phase` becomes 2'b00 one edge later.
- R5: Any other single-line change leaves `seen` unchanged. From phase 01, falling to 10 gives phase 11. From phase 00, reaching 00 gives phase 10. From phase 10, any change gives phase 00. Phase 11 holds until 11 is reached.
- R6: A sample in which both lines changed sets `clash` to 1 for that one cycle and leaves `seen` and `phase` unchanged.
- R7: The state codes are 2'b00 (idle, `seen`=0), 2'b10 (rested at 00, `seen`=0), 2'b01 (both high, `seen`=1) and 2'b11 (holding, `seen`=1). Every change of `phase` flips exactly one bit.
- R8: A sample with no line change leaves `seen`, `phase` and `clash`=0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| sig_x | input | 1 | First watched line |
| sig_y | input | 1 | Second watched line |
| seen | output | 1 | Order-dependent result bit |
| phase | output | 2 | Current state code |
| clash | output | 1 | One-cycle flag for a sample in which both lines changed |

## Verification
Two functions can fall in the same cycle: the comparison that moves the state, and the detection of a double change. When both lines move at once, the edge that would otherwise take a set or clear transition instead raises `clash`. The bench provokes this from each of the four states, including a jump from 00 to 11 that would set `seen` if it were taken as a legal change. It judges the result by requiring `clash` high with `seen` and `phase` frozen in that cycle. It then checks that the next single change is decoded against the new sample, not the one from before the clash.

// File: rtl/order_det_pkg.sv
package order_det_pkg;
  localparam int IN_W    = 2;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_REST = 2'b10,
    ST_BOTH = 2'b01,
    ST_HOLD = 2'b11
  } flow_st_e;

  localparam logic [IN_W-1:0] IN_NONE = 2'b00;
  localparam logic [IN_W-1:0] IN_YONLY = 2'b01;
  localparam logic [IN_W-1:0] IN_ALL  = 2'b11;

  function automatic logic st_result(input flow_st_e st);
    return (st == ST_BOTH) || (st == ST_HOLD);
  endfunction
endpackage

// File: rtl/od_rst_sync.sv
module od_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/od_sampler.sv
module od_sampler #(
  parameter int IN_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] smp_i,
  output logic [IN_W-1:0] prev_o,
  output logic            one_chg_o,
  output logic            multi_chg_o
);
  logic [IN_W-1:0] prev_q;
  logic [IN_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp_i;
  end

  assign diff        = smp_i ^ prev_q;
  assign one_chg_o   = ($countones(diff) == 1);
  assign multi_chg_o = ($countones(diff) > 1);
  assign prev_o      = prev_q;
endmodule

// File: rtl/od_flow_next.sv
module od_flow_next
  import order_det_pkg::*;
(
  input  flow_st_e        cur_st,
  input  logic [IN_W-1:0] prev_in,
  input  logic [IN_W-1:0] now_in,
  output flow_st_e        nxt_st
);
  always_comb begin
    nxt_st = cur_st;
    case (cur_st)
      ST_IDLE: begin
        if (now_in == IN_ALL)       nxt_st = ST_BOTH;
        else if (now_in == IN_NONE) nxt_st = ST_REST;
      end
      ST_REST: nxt_st = ST_IDLE;
      ST_BOTH: begin
        if (now_in == IN_ALL)                              nxt_st = ST_BOTH;
        else if (now_in == IN_YONLY && prev_in == IN_ALL)  nxt_st = ST_IDLE;
        else                                               nxt_st = ST_HOLD;
      end
      ST_HOLD: begin
        if (now_in == IN_ALL) nxt_st = ST_BOTH;
      end
      default: nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/order_det.sv
module order_det
  import order_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_x,
  input  logic               sig_y,
  output logic               seen,
  output logic [STATE_W-1:0] phase,
  output logic               clash
);
  logic            rst_sync_n;
  logic [IN_W-1:0] now_in;
  logic [IN_W-1:0] prev_in;
  logic            step_en;
  logic            multi;
  flow_st_e        state_q;
  flow_st_e        state_d;
  logic            clash_q;

  assign now_in = {sig_x, sig_y};

  od_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  od_sampler #(.IN_W(IN_W)) u_smp (
    .clk(clk), .rst_n(rst_sync_n), .smp_i(now_in),
    .prev_o(prev_in), .one_chg_o(step_en), .multi_chg_o(multi)
  );

  od_flow_next u_nxt (
    .cur_st(state_q), .prev_in(prev_in), .now_in(now_in), .nxt_st(state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  state_q <= ST_IDLE;
    else if (step_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) clash_q <= 1'b0;
    else             clash_q <= multi;
  end

  assign seen  = st_result(state_q);
  assign phase = state_q;
  assign clash = clash_q;
endmodule

// File: rtl/order_det_chk.sv
module order_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seen,
  input logic [1:0] phase,
  input logic       clash
);
  assert_one_bit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> ($countones(phase ^ $past(phase)) == 1));

  assert_clash_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> ($stable(phase) && $stable(seen)));

  assert_set_enters_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen) |-> (phase == 2'b01 && $past(phase) == 2'b00));

  assert_clear_leaves_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seen) |-> (phase == 2'b00 && $past(phase) == 2'b01));

  assert_rest_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'b10 && phase != 2'b10) |-> (phase == 2'b00));
endmodule

bind order_det order_det_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .seen(seen), .phase(phase), .clash(clash)
);

// File: tb/order_det_bench.sv
module order_det_bench;
  localparam int CLK_P = 10;
  localparam logic [1:0] MA = 2'b00, MB = 2'b10, MC = 2'b01, MD = 2'b11;

  typedef struct {
    logic       seen;
    logic [1:0] phase;
    logic       clash;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic sig_x, sig_y;
  logic seen, clash;
  logic [1:0] phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t exp_q[$];

  logic [1:0] m_st;
  logic [1:0] m_prev;

  order_det u_order_det (
    .clk(clk), .rst_n(rst_n), .sig_x(sig_x), .sig_y(sig_y),
    .seen(seen), .phase(phase), .clash(clash)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic compare(input exp_t e);
    checks++;
    if (seen !== e.seen || phase !== e.phase || clash !== e.clash) begin
      fails++;
      $display("FAIL %s: got seen=%b phase=%b clash=%b, expected seen=%b phase=%b clash=%b",
               e.tag, seen, phase, clash, e.seen, e.phase, e.clash);
    end
  endtask

  // monitor: compare one expected item shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  // reference model of the requirements, then push the prediction
  task automatic step(input logic x, input logic y, input string tag);
    logic [1:0] nw;
    logic [1:0] df;
    exp_t e;
    @(negedge clk);
    sig_x = x; sig_y = y;
    nw = {x, y};
    df = nw ^ m_prev;
    e.clash = (df == 2'b11);
    if (df == 2'b01 || df == 2'b10) begin
      if (nw == 2'b11)                                     m_st = MC;
      else if (m_st == MC && m_prev == 2'b11 && nw == 2'b01) m_st = MA;
      else if (m_st == MC)                                 m_st = MD;
      else if (m_st == MA && nw == 2'b00)                  m_st = MB;
      else if (m_st == MB)                                 m_st = MA;
    end
    m_prev  = nw;
    e.phase = m_st;
    e.seen  = (m_st == MC || m_st == MD);
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sig_x = 1'b0; sig_y = 1'b0;
    m_st = MA; m_prev = 2'b00;
    @(negedge clk);
    compare('{1'b0, MA, 1'b0, "R1 during reset"});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare('{1'b0, MA, 1'b0, "R1 after release"});
  endtask

  initial begin
    rst_n = 1'b0; sig_x = 1'b0; sig_y = 1'b0;
    m_st = MA; m_prev = 2'b00;
    do_reset();

    step(1, 0, "R5 idle 00->10 holds");
    step(1, 1, "R3 y rises with x high");
    step(1, 1, "R8 no change in both-high");
    step(1, 0, "R5 11->10 keeps seen, phase 11");
    step(0, 0, "R5 hold state to 00");
    step(0, 1, "R5 hold state to 01");
    step(1, 1, "R2 x rises with y high");
    step(0, 1, "R4 x falls with y high");
    step(0, 0, "R7 idle to rest code 10");
    step(0, 0, "R8 no change at rest");
    step(1, 0, "R5 rest exits to idle");
    step(0, 0, "R7 back to rest");
    step(0, 1, "R5 rest exits to idle via y");
    step(1, 1, "R2 second set path");
    step(0, 0, "R6 clash from both-high");
    step(0, 1, "R5 both-high single change to hold");
    step(1, 0, "R6 clash from hold");
    step(0, 0, "R5 hold to 00");
    step(1, 1, "R6 00->11 jump not taken");
    step(1, 0, "R5 hold after clash");
    step(1, 1, "R3 set from hold");
    step(0, 1, "R4 clear again");
    step(1, 0, "R6 clash from idle");
    step(0, 0, "R7 to rest");
    step(1, 1, "R6 clash from rest");
    step(0, 1, "R5 rest exits after clash");
    step(1, 1, "R2 set before reset");
    repeat (3) @(negedge clk);
    do_reset();
    step(0, 1, "R5 idle after second reset");
    step(1, 1, "R2 set after second reset");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule